// File: doc/BRIEF.md
# Programmable Two-State Resonator Emulator

This block replaces a resonant cavity, or any other second-order linear plant, with a real-time model that runs at the converter sample rate. At each sample strobe it takes one code from the input converter and updates a two-element state vector through a programmable 2x2 feedback matrix and a 2x1 input vector. It also drives the output converter with a 1x2 projection of the state. There is no direct path from input to output.

A host loads the eight coefficients through an address/data register pair. It first loads an address register. A write to the data register then places a word into the coefficient that address selects, and the read port returns the stored word for the current address. Coefficients are signed fixed-point with 30 fractional bits, so the largest positive code stands for unity. With the identity-like setting (feedback zero, input and output weights at unity) the output repeats the input one sample later. With a damped rotation in the feedback matrix, an impulse rings down as a decaying sinusoid.

Top module: `resonator_sim`

## Requirements
- R1: After reset both state elements and all coefficients are zero, `dacCode` is 14'h2000 (the code for zero), `dacValid` is low, and every address reads back zero.
- R2: Address codes select coefficients as 1=feedback row0/col0, 2=row0/col1, 3=row1/col0, 4=row1/col1, 5=input weight 0, 6=input weight 1, 7=output weight 0, 8=output weight 1. A data write stores the 31-bit word at the address held in the address register, and `hostRdData` returns that word from the cycle after the write.
- R3: Writes to an address outside 1..8 change no coefficient, and such addresses read back zero.
- R4: A coefficient write is used in arithmetic only from the second sample strobe after the write. The strobe that follows the write still uses the old value.
- R5: On a strobe the next state is s0'=k11*s0+k12*s1+g0*u and s1'=k21*s0+k22*s1+g1*u. On the same edge `dacCode` takes h0*s0+h1*s1 computed from the state held before that edge, so input sample k appears at the output on strobe k+1. `dacValid` is high in the cycle after each strobe and low otherwise. State and output hold between strobes.
- R6: Converter codes are offset binary: code = signed value + 8192, so 14'h2000 is zero, 14'h0000 is -8192 and 14'h3FFF is +8191. With unity input and output weights and zero feedback, every one of the 16384 input codes comes back unchanged one strobe later.
- R7: Each sum is rounded at the 2^-30 weight by adding one half LSB and then shifting arithmetically (half rounds toward plus infinity). For example, weight 0.5 maps inputs 1, -1, 3, -3 to 1, 0, 2, -1.
- R8: Each state element saturates to the signed 16-bit range, and the output saturates to the signed 14-bit range (codes 14'h3FFF and 14'h0000). Neither wraps.
- R9: With the feedback matrix set to lambda times a rotation, an impulse produces a sign-alternating decaying oscillation, and the ring-down lasts longer for lambda 0.9 than for lambda 0.6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe; one pulse per converter sample |
| adcCode | input | 14 | Input converter code, offset binary |
| dacCode | output | 14 | Output converter code, offset binary |
| dacValid | output | 1 | High in the cycle after a strobe |
| hostAddrWe | input | 1 | Loads the address register |
| hostAddr | input | 14 | New address value |
| hostDataWe | input | 1 | Writes hostData to the addressed coefficient |
| hostData | input | 31 | Coefficient word, signed, 30 fractional bits |
| hostRdData | output | 31 | Stored word at the current address, zero when out of range |

## Verification
The embedded properties check several behaviours on every cycle. They confirm that output, state and live coefficient bank change only on a strobe, and that the valid flag follows the strobe. They confirm that an out-of-range address reads zero and that a data write is visible on readback one cycle later. The arithmetic itself can only be shown by the bench's scenarios. These are an exhaustive pass of every input code through the unity setting, exact rounding cases, driving the state into both saturation limits, the one-strobe delay of a coefficient change, and two damped-rotation ring-downs compared sample by sample against an arithmetic model.

// File: rtl/resonator_pkg.sv
package resonator_pkg;

  localparam int NUM_COEF = 8;

  // Index of each coefficient inside the bank (host address minus one)
  typedef enum logic [2:0] {
    SEL_K11 = 3'd0,
    SEL_K12 = 3'd1,
    SEL_K21 = 3'd2,
    SEL_K22 = 3'd3,
    SEL_G0  = 3'd4,
    SEL_G1  = 3'd5,
    SEL_H0  = 3'd6,
    SEL_H1  = 3'd7
  } coefSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;    // advance state and refresh output
    logic commit;  // copy staged coefficients into the live bank
  } ctrlStrobe_t;

endpackage

// File: rtl/resonator_ctrl.sv
module resonator_ctrl
  import resonator_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int COEF_W = 31
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               sampleValid,
  input  logic                               hostAddrWe,
  input  logic [ADDR_W-1:0]                  hostAddr,
  input  logic                               hostDataWe,
  input  logic [COEF_W-1:0]                  hostData,
  output logic [COEF_W-1:0]                  hostRdData,
  output ctrlStrobe_t                        strobe,
  output logic [NUM_COEF-1:0][COEF_W-1:0]    liveCoefs
);

  localparam int IDX_W = $clog2(NUM_COEF);

  logic [ADDR_W-1:0]               addrReg;
  logic [NUM_COEF-1:0][COEF_W-1:0] stagedCoefs;
  logic                            addrValid;
  logic [IDX_W-1:0]                addrIdx;

  assign addrValid = (addrReg >= ADDR_W'(1)) && (addrReg <= ADDR_W'(NUM_COEF));
  assign addrIdx   = IDX_W'(addrReg - ADDR_W'(1));

  assign strobe.step   = sampleValid;
  assign strobe.commit = sampleValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (hostAddrWe) begin
      addrReg <= hostAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedCoefs <= '0;
    end else if (hostDataWe && addrValid) begin
      stagedCoefs[addrIdx] <= hostData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCoefs <= '0;
    end else if (strobe.commit) begin
      liveCoefs <= stagedCoefs;
    end
  end

  always_comb begin
    hostRdData = '0;
    if (addrValid) hostRdData = stagedCoefs[addrIdx];
  end

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> hostRdData == '0); // R3

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (hostDataWe && addrValid && !hostAddrWe) |=> hostRdData == $past(hostData)); // R2

  AST_LIVE_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(liveCoefs)); // R4

endmodule

// File: rtl/resonator_datapath.sv
module resonator_datapath
  import resonator_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int STATE_W  = 16,
  parameter int COEF_W   = 31,
  parameter int FRAC_W   = 30
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strobe,
  input  logic [NUM_COEF-1:0][COEF_W-1:0] liveCoefs,
  input  logic [SAMPLE_W-1:0]             adcCode,
  output logic [SAMPLE_W-1:0]             dacCode,
  output logic                            dacValid
);

  localparam int ACC_W = COEF_W + STATE_W + 2;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(longint'(1) <<< (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] ST_MAX   = ACC_W'((longint'(1) <<< (STATE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] ST_MIN   = -ST_MAX - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] OUT_MAX  = ACC_W'((longint'(1) <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN  = -OUT_MAX - ACC_W'(1);

  function automatic logic signed [ACC_W-1:0] mulTerm(
    input logic [COEF_W-1:0] coef, input logic signed [STATE_W-1:0] val);
    logic signed [ACC_W-1:0] cExt, vExt;
    cExt = ACC_W'($signed(coef));
    vExt = ACC_W'(val);
    return cExt * vExt;
  endfunction

  function automatic logic signed [ACC_W-1:0] roundFrac(input logic signed [ACC_W-1:0] acc);
    return (acc + HALF_LSB) >>> FRAC_W;
  endfunction

  function automatic logic signed [STATE_W-1:0] clampState(input logic signed [ACC_W-1:0] v);
    if (v > ST_MAX) return ST_MAX[STATE_W-1:0];
    if (v < ST_MIN) return ST_MIN[STATE_W-1:0];
    return v[STATE_W-1:0];
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] clampOut(input logic signed [ACC_W-1:0] v);
    if (v > OUT_MAX) return OUT_MAX[SAMPLE_W-1:0];
    if (v < OUT_MIN) return OUT_MIN[SAMPLE_W-1:0];
    return v[SAMPLE_W-1:0];
  endfunction

  logic signed [SAMPLE_W-1:0] uSigned;
  logic signed [STATE_W-1:0]  uExt;
  logic signed [STATE_W-1:0]  stateReg [2];
  logic signed [ACC_W-1:0]    outAcc;
  logic signed [SAMPLE_W-1:0] outSat;

  // offset binary to two's complement: flip the sign bit
  assign uSigned = {~adcCode[SAMPLE_W-1], adcCode[SAMPLE_W-2:0]};
  assign uExt    = STATE_W'(uSigned);

  for (genvar r = 0; r < 2; r++) begin : g_row
    logic signed [ACC_W-1:0] rowAcc;
    assign rowAcc = mulTerm(liveCoefs[2*r],     stateReg[0])
                  + mulTerm(liveCoefs[2*r + 1], stateReg[1])
                  + mulTerm(liveCoefs[SEL_G0 + r], uExt);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateReg[r] <= '0;
      end else if (strobe.step) begin
        stateReg[r] <= clampState(roundFrac(rowAcc));
      end
    end
  end

  assign outAcc = mulTerm(liveCoefs[SEL_H0], stateReg[0])
                + mulTerm(liveCoefs[SEL_H1], stateReg[1]);
  assign outSat = clampOut(roundFrac(outAcc));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacCode  <= {1'b1, {(SAMPLE_W-1){1'b0}}};
      dacValid <= 1'b0;
    end else begin
      dacValid <= strobe.step;
      if (strobe.step) dacCode <= {~outSat[SAMPLE_W-1], outSat[SAMPLE_W-2:0]};
    end
  end

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(dacCode)); // R5

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> ($stable(stateReg[0]) && $stable(stateReg[1]))); // R5

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> dacValid); // R5

  AST_VALID_ONLY_AFTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> !dacValid); // R5

endmodule

// File: rtl/resonator_sim.sv
module resonator_sim
  import resonator_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int STATE_W  = 16,
  parameter int COEF_W   = 31,
  parameter int FRAC_W   = 30,
  parameter int ADDR_W   = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] adcCode,
  output logic [SAMPLE_W-1:0] dacCode,
  output logic                dacValid,
  input  logic                hostAddrWe,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic                hostDataWe,
  input  logic [COEF_W-1:0]   hostData,
  output logic [COEF_W-1:0]   hostRdData
);

  ctrlStrobe_t                     strobe;
  logic [NUM_COEF-1:0][COEF_W-1:0] liveCoefs;

  resonator_ctrl #(
    .ADDR_W (ADDR_W),
    .COEF_W (COEF_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .hostAddrWe  (hostAddrWe),
    .hostAddr    (hostAddr),
    .hostDataWe  (hostDataWe),
    .hostData    (hostData),
    .hostRdData  (hostRdData),
    .strobe      (strobe),
    .liveCoefs   (liveCoefs)
  );

  resonator_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .STATE_W  (STATE_W),
    .COEF_W   (COEF_W),
    .FRAC_W   (FRAC_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .liveCoefs (liveCoefs),
    .adcCode   (adcCode),
    .dacCode   (dacCode),
    .dacValid  (dacValid)
  );

endmodule

// File: tb/resonator_sim_bench.sv
module resonator_sim_bench;

  localparam int CLK_PERIOD = 10;
  localparam longint UNITY = (longint'(1) <<< 30) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [13:0] adcCode = 14'h2000;
  logic [13:0] dacCode;
  logic        dacValid;
  logic        hostAddrWe = 1'b0;
  logic [13:0] hostAddr = '0;
  logic        hostDataWe = 1'b0;
  logic [30:0] hostData = '0;
  logic [30:0] hostRdData;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // arithmetic model of the requirements
  longint staged [8];
  longint live [8];
  longint s0 = 0, s1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resonator_sim u_resonator_sim (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .adcCode(adcCode),
    .dacCode(dacCode), .dacValid(dacValid), .hostAddrWe(hostAddrWe),
    .hostAddr(hostAddr), .hostDataWe(hostDataWe), .hostData(hostData),
    .hostRdData(hostRdData)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint rnd(input longint acc);
    return (acc + (longint'(1) <<< 29)) >>> 30;
  endfunction

  function automatic longint clip(input longint v, input int bits);
    longint hi = (longint'(1) <<< (bits - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  task automatic writeCoef(input int addr, input longint val);
    @(negedge clk); hostAddr = 14'(addr); hostAddrWe = 1'b1;
    @(negedge clk); hostAddrWe = 1'b0; hostDataWe = 1'b1; hostData = 31'(val);
    @(negedge clk); hostDataWe = 1'b0;
    if (addr >= 1 && addr <= 8) staged[addr-1] = val;
  endtask

  task automatic readCoef(input int addr, output longint val);
    @(negedge clk); hostAddr = 14'(addr); hostAddrWe = 1'b1;
    @(negedge clk); hostAddrWe = 1'b0;
    val = longint'($signed(hostRdData));
  endtask

  // one strobe; returns the signed output seen and the expected value
  task automatic sample(input longint u, output longint got, output longint exp);
    longint n0, n1;
    @(negedge clk); adcCode = 14'(u + 8192); sampleValid = 1'b1;
    @(negedge clk); sampleValid = 1'b0;
    got = longint'(dacCode) - 8192;
    check("R5 valid", longint'(dacValid), 1);
    exp = clip(rnd(live[6]*s0 + live[7]*s1), 14);
    n0 = clip(rnd(live[0]*s0 + live[1]*s1 + live[4]*u), 16);
    n1 = clip(rnd(live[2]*s0 + live[3]*s1 + live[5]*u), 16);
    s0 = n0; s1 = n1;
    for (int i = 0; i < 8; i++) live[i] = staged[i];
  endtask

  task automatic loadAll(input longint k11, input longint k12, input longint k21,
                         input longint k22, input longint g0, input longint g1,
                         input longint h0, input longint h1);
    longint g, e;
    writeCoef(1, k11); writeCoef(2, k12); writeCoef(3, k21); writeCoef(4, k22);
    writeCoef(5, g0);  writeCoef(6, g1);  writeCoef(7, h0);  writeCoef(8, h1);
    sample(0, g, e);  // commit
  endtask

  task automatic ringDown(input real lambda, output int lastBig, output int signFlips);
    longint g, e, prev;
    real th = 2.0 * 3.14159265358979 / 12.0;
    longint c = longint'($rtoi(lambda * $cos(th) * 1073741824.0));
    longint s = longint'($rtoi(lambda * $sin(th) * 1073741824.0));
    loadAll(0, 0, 0, 0, 0, 0, 0, 0);
    sample(0, g, e); sample(0, g, e);            // clear state
    loadAll(c, -s, s, c, UNITY, 0, UNITY, 0);
    lastBig = 0; signFlips = 0; prev = 0;
    sample(8191, g, e);
    check("R9 impulse", g, e);
    for (int i = 1; i < 250; i++) begin
      sample(0, g, e);
      check("R9 ring", g, e);
      if (g >= 64 || g <= -64) lastBig = i;
      if ((g > 0 && prev < 0) || (g < 0 && prev > 0)) signFlips++;
      if (g != 0) prev = g;
    end
  endtask

  initial begin
    longint v, g, e;
    int lastA, lastB, flipA, flipB;
    for (int i = 0; i < 8; i++) begin staged[i] = 0; live[i] = 0; end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dac", longint'(dacCode), 64'h2000);
    check("R1 valid", longint'(dacValid), 0);
    for (int a = 1; a <= 8; a++) begin
      readCoef(a, v); check("R1 readback", v, 0);
    end

    // R2 map and readback
    for (int a = 1; a <= 8; a++) writeCoef(a, longint'(a) * 1000 - 3000);
    for (int a = 1; a <= 8; a++) begin
      readCoef(a, v); check("R2 readback", v, staged[a-1]);
    end
    // R3 out-of-range writes ignored
    writeCoef(0, 12345); writeCoef(9, 777); writeCoef(16383, -5);
    readCoef(0, v); check("R3 addr0", v, 0);
    readCoef(9, v); check("R3 addr9", v, 0);
    readCoef(16383, v); check("R3 addrTop", v, 0);
    for (int a = 1; a <= 8; a++) begin
      readCoef(a, v); check("R3 untouched", v, staged[a-1]);
    end

    // R6 exhaustive pass-through sweep
    loadAll(0, 0, 0, 0, UNITY, 0, UNITY, 0);
    sample(0, g, e);
    for (int code = 0; code < 16384; code++) begin
      sample(longint'(code) - 8192, g, e);
      if (code > 0) check("R6 passthrough", g, longint'(code) - 1 - 8192);
    end
    sample(0, g, e); check("R6 last code", g, 8191);

    // R4 double buffering
    sample(500, g, e);
    writeCoef(7, 0);
    sample(0, g, e); check("R4 old weight still used", g, 500);
    sample(0, g, e); check("R4 new weight used", g, 0);

    // R7 rounding with weight 0.5
    loadAll(0, 0, 0, 0, longint'(1) <<< 29, 0, UNITY, 0);
    sample(1, g, e);
    sample(-1, g, e); check("R7 round +0.5", g, 1);
    sample(3, g, e);  check("R7 round -0.5", g, 0);
    sample(-3, g, e); check("R7 round 1.5", g, 2);
    sample(0, g, e);  check("R7 round -1.5", g, -1);

    // R8 saturation: integrator driven hard both ways
    loadAll(UNITY, 0, 0, 0, UNITY, 0, UNITY, 0);
    for (int i = 0; i < 10; i++) begin
      sample(8191, g, e); check("R8 model up", g, e);
    end
    check("R8 top code", g, 8191);
    for (int i = 0; i < 14; i++) begin
      sample(-8192, g, e); check("R8 model down", g, e);
    end
    check("R8 bottom code", g, -8192);
    check("R8 state floor", s0, -32768);

    // R5 general state update with cross terms, checked against the model
    loadAll(-400000000, 300000000, 500000000, 200000000,
            700000000, -600000000, 450000000, -350000000);
    for (int i = 0; i < 40; i++) begin
      sample(((i * 2731) % 16384) - 8192, g, e); check("R5 cross terms", g, e);
    end

    // R9 damped rotation ring-down
    ringDown(0.6, lastA, flipA);
    ringDown(0.9, lastB, flipB);
    check("R9 oscillates", longint'(flipB >= 4), 1);
    check("R9 longer decay", longint'(lastB > lastA), 1);
    check("R9 decays", longint'(lastB < 240), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule